// File: doc/BRIEF.md
# Split-Byte Down-Counting PWM Timer

This block holds two independent 8-bit down-counters, a low lane and a high lane, that advance together on one shared timer-clock enable. Each lane loads its period value (TOP) after it reaches zero (BOTTOM), then counts down again. Every lane has its own set of compare channels. Each channel makes a single-slope PWM waveform that goes high when the count reaches the channel's compare value and goes low at BOTTOM. The period sets the PWM frequency and the compare value sets the duty cycle.

Only the low lane reports compare matches. Each of its channels has a sticky flag, a one-cycle event pulse and a maskable interrupt request. Both lanes raise a sticky underflow flag on every reload. A waveform reaches its pin only when the channel's override enable is set and the pin's direction bit selects output. A per-pin invert control can flip the level. Software programs the block through a simple write port: one strobe, an address and a data byte.

Top module: `pwm_split_timer`

## Requirements
- R1: After reset both counts are zero, both periods are 0xFF, all compare values, enables, inverts and interrupt masks are zero, and every pin, flag, event and interrupt output is low.
- R2: A write with wr_en high updates the addressed register at that clock edge. The addresses are: 0 low period, 1 high period, 2 low pin enables, 3 high pin enables, 4 low inverts, 5 high inverts, 6 flag clear, 7 low interrupt mask, 8+i low compare i, 8+NCH_LO+j high compare j. In the mask registers, bit i belongs to channel i.
- R3: A count of zero loads the current period on the next tick. Any other count decrements. A period write takes effect without buffering, so the next reload uses it whether it is above or below the running count.
- R4: A channel's waveform is set on the tick that moves the count to its compare value and cleared on the tick that moves the count to zero. Clear wins a collision. With period P and compare C, the waveform is high for C ticks of every P+1 when 1 ≤ C ≤ P, and it is never high when C = 0 or C > P.
- R5: One tick after the tick that moved the low count to a low channel's compare value, that channel's flag is set and its event output pulses high for exactly one clock.
- R6: The high lane's compare matches produce no flag and no event.
- R7: Writing address 6 clears each low compare flag whose bit i is 1. A hardware set in the same cycle wins over the clear.
- R8: Each low interrupt output is high exactly when that channel's flag and mask bit are both set.
- R9: A pin is driven low whenever its direction bit is 0. With direction 1 and the enable bit 0, the pin shows the invert bit alone. With both set, it shows the waveform.
- R10: An invert bit of 1 inverts the level the channel drives onto its pin.
- R11: Each lane's underflow flag is set by a tick taken at count zero and stays set until a write to address 6 has bit 6 (low lane) or bit 7 (high lane) at 1. A hardware set wins over the clear.
- R12: In cycles where tick is low, counts, waveforms and flags hold and no event is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Shared prescaled timer-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CNT_W | Register write data |
| dir_lo | input | NCH_LO | Direction bits of the low-lane pins (1 = output) |
| dir_hi | input | NCH_HI | Direction bits of the high-lane pins (1 = output) |
| pin_lo | output | NCH_LO | Low-lane pin levels |
| pin_hi | output | NCH_HI | High-lane pin levels |
| cmp_flag_lo | output | NCH_LO | Sticky low-lane compare flags |
| cmp_evt_lo | output | NCH_LO | One-clock low-lane compare events |
| cmp_irq_lo | output | NCH_LO | Masked low-lane compare interrupt requests |
| unf_lo | output | 1 | Sticky low-lane underflow flag |
| unf_hi | output | 1 | Sticky high-lane underflow flag |

## Verification
A waveform changes at the same rising edge as the tick that moves the count to the compare value or to zero. A direction change reaches the pin without any clock edge, while enable, invert and mask writes act from the edge that takes the write. Compare flags and events appear one tick after the count reaches the compare value, and an underflow flag appears at the edge of the reload tick. The bench updates a cycle-level model of these rules at each rising edge, checks every output at the following falling edge, and counts pin highs over whole periods to check the duty cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

   // Register addresses of the write port
   localparam int unsigned ADR_PER_LO   = 0;
   localparam int unsigned ADR_PER_HI   = 1;
   localparam int unsigned ADR_EN_LO    = 2;
   localparam int unsigned ADR_EN_HI    = 3;
   localparam int unsigned ADR_INV_LO   = 4;
   localparam int unsigned ADR_INV_HI   = 5;
   localparam int unsigned ADR_FLAG_CLR = 6;
   localparam int unsigned ADR_IRQ_EN   = 7;
   localparam int unsigned ADR_CMP_BASE = 8;

   // What a tick does to a waveform register
   typedef enum logic [1:0] {
      WV_HOLD  = 2'd0,
      WV_SET   = 2'd1,
      WV_CLEAR = 2'd2
   } wave_act_e;

endpackage

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] per,
   input  logic         unf_clr,
   output logic [W-1:0] cnt_nxt,
   output logic         unf
);

   logic [W-1:0] cnt_q;
   logic         at_bottom;

   assign at_bottom = (cnt_q == '0);

   // The period is read live, so a write is used at the next reload
   always_comb begin
      cnt_nxt = cnt_q;
      if (tick) begin
         cnt_nxt = at_bottom ? per : cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         unf   <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         if (tick && at_bottom) begin
            unf <= 1'b1;
         end else if (unf_clr) begin
            unf <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pwm_wave_bank.sv
module pwm_wave_bank
   import pwm_timer_pkg::*;
#(
   parameter int unsigned W   = 8,
   parameter int unsigned NCH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic [W-1:0]            cnt_nxt,
   input  logic [NCH-1:0][W-1:0]   cmp,
   output logic [NCH-1:0]          wave
);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      wave_act_e act;

      // Reaching BOTTOM has priority over a match
      always_comb begin
         act = WV_HOLD;
         if (tick) begin
            if (cnt_nxt == '0) begin
               act = WV_CLEAR;
            end else if (cnt_nxt == cmp[i]) begin
               act = WV_SET;
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wave[i] <= 1'b0;
         end else begin
            case (act)
               WV_SET:   wave[i] <= 1'b1;
               WV_CLEAR: wave[i] <= 1'b0;
               default:  wave[i] <= wave[i];
            endcase
         end
      end
   end

endmodule

// File: rtl/pwm_match_flags.sv
module pwm_match_flags #(
   parameter int unsigned W   = 8,
   parameter int unsigned NCH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic [W-1:0]            cnt_nxt,
   input  logic [NCH-1:0][W-1:0]   cmp,
   input  logic [NCH-1:0]          clr,
   output logic [NCH-1:0]          flag,
   output logic [NCH-1:0]          evt
);

   logic [NCH-1:0] pend;

   // A match is recorded when the count arrives and reported on the next tick
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[i] <= 1'b0;
            evt[i]  <= 1'b0;
            flag[i] <= 1'b0;
         end else begin
            if (tick) begin
               pend[i] <= (cnt_nxt == cmp[i]);
            end
            evt[i] <= tick && pend[i];
            if (tick && pend[i]) begin
               flag[i] <= 1'b1;
            end else if (clr[i]) begin
               flag[i] <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/pwm_pin_drive.sv
module pwm_pin_drive #(
   parameter int unsigned NCH = 2
) (
   input  logic [NCH-1:0] wave,
   input  logic [NCH-1:0] en,
   input  logic [NCH-1:0] inv,
   input  logic [NCH-1:0] dir,
   output logic [NCH-1:0] pin
);

   for (genvar i = 0; i < NCH; i++) begin : g_pin
      logic level;
      assign level  = (en[i] & wave[i]) ^ inv[i];
      assign pin[i] = dir[i] & level;
   end

endmodule

// File: rtl/pwm_split_timer.sv
module pwm_split_timer
   import pwm_timer_pkg::*;
#(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned NCH_LO = 4,
   parameter int unsigned NCH_HI = 2,
   parameter int unsigned AW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [NCH_LO-1:0] dir_lo,
   input  logic [NCH_HI-1:0] dir_hi,
   output logic [NCH_LO-1:0] pin_lo,
   output logic [NCH_HI-1:0] pin_hi,
   output logic [NCH_LO-1:0] cmp_flag_lo,
   output logic [NCH_LO-1:0] cmp_evt_lo,
   output logic [NCH_LO-1:0] cmp_irq_lo,
   output logic              unf_lo,
   output logic              unf_hi
);

   localparam int unsigned NREG       = ADR_CMP_BASE + NCH_LO + NCH_HI;
   localparam int unsigned UNF_LO_BIT = CNT_W - 2;
   localparam int unsigned UNF_HI_BIT = CNT_W - 1;

   localparam logic [AW-1:0] A_PER_LO = AW'(ADR_PER_LO);
   localparam logic [AW-1:0] A_PER_HI = AW'(ADR_PER_HI);
   localparam logic [AW-1:0] A_EN_LO  = AW'(ADR_EN_LO);
   localparam logic [AW-1:0] A_EN_HI  = AW'(ADR_EN_HI);
   localparam logic [AW-1:0] A_INV_LO = AW'(ADR_INV_LO);
   localparam logic [AW-1:0] A_INV_HI = AW'(ADR_INV_HI);
   localparam logic [AW-1:0] A_CLR    = AW'(ADR_FLAG_CLR);
   localparam logic [AW-1:0] A_IE     = AW'(ADR_IRQ_EN);

   // Elaboration-time parameter checks
   if (CNT_W < 3) begin : g_bad_w
      $error("CNT_W must be at least 3");
   end
   if (NCH_LO < 1 || NCH_LO > CNT_W - 2) begin : g_bad_lo
      $error("NCH_LO must lie in 1..CNT_W-2");
   end
   if (NCH_HI < 1 || NCH_HI > CNT_W) begin : g_bad_hi
      $error("NCH_HI must lie in 1..CNT_W");
   end
   if (NREG > (1 << AW)) begin : g_bad_aw
      $error("AW too narrow for the register map");
   end

   // Register file
   logic [CNT_W-1:0]              per_lo, per_hi;
   logic [NCH_LO-1:0]             en_lo, inv_lo, ie_lo;
   logic [NCH_HI-1:0]             en_hi, inv_hi;
   logic [NCH_LO-1:0][CNT_W-1:0]  cmp_lo;
   logic [NCH_HI-1:0][CNT_W-1:0]  cmp_hi;
   logic [CNT_W-1:0]              clr_vec;

   function automatic logic hit(input logic [AW-1:0] a);
      return wr_en && (wr_addr == a);
   endfunction

   assign clr_vec = hit(A_CLR) ? wr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_lo <= '1;
         per_hi <= '1;
         en_lo  <= '0;
         en_hi  <= '0;
         inv_lo <= '0;
         inv_hi <= '0;
         ie_lo  <= '0;
      end else begin
         if (hit(A_PER_LO)) per_lo <= wr_data;
         if (hit(A_PER_HI)) per_hi <= wr_data;
         if (hit(A_EN_LO))  en_lo  <= wr_data[NCH_LO-1:0];
         if (hit(A_EN_HI))  en_hi  <= wr_data[NCH_HI-1:0];
         if (hit(A_INV_LO)) inv_lo <= wr_data[NCH_LO-1:0];
         if (hit(A_INV_HI)) inv_hi <= wr_data[NCH_HI-1:0];
         if (hit(A_IE))     ie_lo  <= wr_data[NCH_LO-1:0];
      end
   end

   for (genvar i = 0; i < NCH_LO; i++) begin : g_cmp_lo
      localparam logic [AW-1:0] ADR = AW'(ADR_CMP_BASE + i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_lo[i] <= '0;
         end else if (hit(ADR)) begin
            cmp_lo[i] <= wr_data;
         end
      end
   end

   for (genvar j = 0; j < NCH_HI; j++) begin : g_cmp_hi
      localparam logic [AW-1:0] ADR = AW'(ADR_CMP_BASE + NCH_LO + j);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_hi[j] <= '0;
         end else if (hit(ADR)) begin
            cmp_hi[j] <= wr_data;
         end
      end
   end

   // Low lane: counter, waveforms, compare flags
   logic [CNT_W-1:0]  nxt_lo, nxt_hi;
   logic [NCH_LO-1:0] wave_lo;
   logic [NCH_HI-1:0] wave_hi;

   pwm_down_counter #(.W(CNT_W)) u_cnt_lo (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .per     (per_lo),
      .unf_clr (clr_vec[UNF_LO_BIT]),
      .cnt_nxt (nxt_lo),
      .unf     (unf_lo)
   );

   pwm_wave_bank #(.W(CNT_W), .NCH(NCH_LO)) u_wave_lo (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cnt_nxt (nxt_lo),
      .cmp     (cmp_lo),
      .wave    (wave_lo)
   );

   pwm_match_flags #(.W(CNT_W), .NCH(NCH_LO)) u_flags_lo (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cnt_nxt (nxt_lo),
      .cmp     (cmp_lo),
      .clr     (clr_vec[NCH_LO-1:0]),
      .flag    (cmp_flag_lo),
      .evt     (cmp_evt_lo)
   );

   pwm_pin_drive #(.NCH(NCH_LO)) u_pin_lo (
      .wave (wave_lo),
      .en   (en_lo),
      .inv  (inv_lo),
      .dir  (dir_lo),
      .pin  (pin_lo)
   );

   // High lane: counter and waveforms only
   pwm_down_counter #(.W(CNT_W)) u_cnt_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .per     (per_hi),
      .unf_clr (clr_vec[UNF_HI_BIT]),
      .cnt_nxt (nxt_hi),
      .unf     (unf_hi)
   );

   pwm_wave_bank #(.W(CNT_W), .NCH(NCH_HI)) u_wave_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cnt_nxt (nxt_hi),
      .cmp     (cmp_hi),
      .wave    (wave_hi)
   );

   pwm_pin_drive #(.NCH(NCH_HI)) u_pin_hi (
      .wave (wave_hi),
      .en   (en_hi),
      .inv  (inv_hi),
      .dir  (dir_hi),
      .pin  (pin_hi)
   );

   assign cmp_irq_lo = cmp_flag_lo & ie_lo;

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
   parameter int unsigned NL = 4,
   parameter int unsigned NH = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          wr_en,
   input logic [NL-1:0] dir_lo,
   input logic [NH-1:0] dir_hi,
   input logic [NL-1:0] pin_lo,
   input logic [NH-1:0] pin_hi,
   input logic [NL-1:0] flag,
   input logic [NL-1:0] evt,
   input logic [NL-1:0] irq,
   input logic          unf_lo,
   input logic          unf_hi
);

   p_pin_dir_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_lo & ~dir_lo) == '0);

   p_pin_dir_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_hi & ~dir_hi) == '0);

   p_evt_has_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt & ~flag) == '0);

   p_irq_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~flag) == '0);

   p_no_evt_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (evt == '0));

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (($past(flag) & ~flag) == '0));

   p_unf_lo_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unf_lo) |-> $past(tick));

   p_unf_hi_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unf_hi) |-> $past(tick));

   p_unf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_lo && !wr_en) |=> unf_lo);

endmodule

bind pwm_split_timer pwm_timer_chk #(.NL(NCH_LO), .NH(NCH_HI)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .wr_en  (wr_en),
   .dir_lo (dir_lo),
   .dir_hi (dir_hi),
   .pin_lo (pin_lo),
   .pin_hi (pin_hi),
   .flag   (cmp_flag_lo),
   .evt    (cmp_evt_lo),
   .irq    (cmp_irq_lo),
   .unf_lo (unf_lo),
   .unf_hi (unf_hi)
);

// File: tb/tb_pwm_split_timer.sv
module tb_pwm_split_timer;

   localparam int NL = 4;
   localparam int NH = 2;
   localparam int W  = 8;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [NL-1:0] dir_lo = '0;
   logic [NH-1:0] dir_hi = '0;
   logic [NL-1:0] pin_lo, cmp_flag_lo, cmp_evt_lo, cmp_irq_lo;
   logic [NH-1:0] pin_hi;
   logic          unf_lo, unf_hi;

   int n_chk = 0;
   int n_bad = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   pwm_split_timer #(.CNT_W(W), .NCH_LO(NL), .NCH_HI(NH), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .dir_lo(dir_lo), .dir_hi(dir_hi), .pin_lo(pin_lo),
      .pin_hi(pin_hi), .cmp_flag_lo(cmp_flag_lo), .cmp_evt_lo(cmp_evt_lo),
      .cmp_irq_lo(cmp_irq_lo), .unf_lo(unf_lo), .unf_hi(unf_hi)
   );

   // Behavioural model of the requirements
   logic [W-1:0]  m_cnt_lo, m_cnt_hi, m_per_lo, m_per_hi;
   logic [W-1:0]  m_cmp_lo [NL];
   logic [W-1:0]  m_cmp_hi [NH];
   logic [NL-1:0] m_en_lo, m_inv_lo, m_ie, m_wave_lo, m_pend, m_flag, m_evt;
   logic [NH-1:0] m_en_hi, m_inv_hi, m_wave_hi;
   logic          m_unf_lo, m_unf_hi;
   logic [W-1:0]  nl, nh, clrv;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt_lo <= '0; m_cnt_hi <= '0; m_per_lo <= '1; m_per_hi <= '1;
         for (int i = 0; i < NL; i++) m_cmp_lo[i] <= '0;
         for (int j = 0; j < NH; j++) m_cmp_hi[j] <= '0;
         m_en_lo <= '0; m_inv_lo <= '0; m_ie <= '0; m_wave_lo <= '0;
         m_pend <= '0; m_flag <= '0; m_evt <= '0;
         m_en_hi <= '0; m_inv_hi <= '0; m_wave_hi <= '0;
         m_unf_lo <= 1'b0; m_unf_hi <= 1'b0;
      end else begin
         nl = (m_cnt_lo == 0) ? m_per_lo : m_cnt_lo - 1'b1;
         nh = (m_cnt_hi == 0) ? m_per_hi : m_cnt_hi - 1'b1;
         clrv = (wr_en && wr_addr == 6) ? wr_data : '0;
         if (tick) begin
            m_cnt_lo <= nl;
            m_cnt_hi <= nh;
            for (int i = 0; i < NL; i++) begin
               if (nl == 0) m_wave_lo[i] <= 1'b0;
               else if (nl == m_cmp_lo[i]) m_wave_lo[i] <= 1'b1;
               m_pend[i] <= (nl == m_cmp_lo[i]);
            end
            for (int j = 0; j < NH; j++) begin
               if (nh == 0) m_wave_hi[j] <= 1'b0;
               else if (nh == m_cmp_hi[j]) m_wave_hi[j] <= 1'b1;
            end
         end
         m_evt    <= tick ? m_pend : '0;
         m_flag   <= (m_flag & ~clrv[NL-1:0]) | (tick ? m_pend : '0);
         m_unf_lo <= (tick && m_cnt_lo == 0) || (m_unf_lo && !clrv[6]);
         m_unf_hi <= (tick && m_cnt_hi == 0) || (m_unf_hi && !clrv[7]);
         if (wr_en) begin
            case (wr_addr)
               0: m_per_lo <= wr_data;
               1: m_per_hi <= wr_data;
               2: m_en_lo  <= wr_data[NL-1:0];
               3: m_en_hi  <= wr_data[NH-1:0];
               4: m_inv_lo <= wr_data[NL-1:0];
               5: m_inv_hi <= wr_data[NH-1:0];
               7: m_ie     <= wr_data[NL-1:0];
               default: begin
                  for (int i = 0; i < NL; i++)
                     if (int'(wr_addr) == 8 + i) m_cmp_lo[i] <= wr_data;
                  for (int j = 0; j < NH; j++)
                     if (int'(wr_addr) == 8 + NL + j) m_cmp_hi[j] <= wr_data;
               end
            endcase
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      logic [NL-1:0] epl;
      logic [NH-1:0] eph;
      epl = dir_lo & ((m_en_lo & m_wave_lo) ^ m_inv_lo);
      eph = dir_hi & ((m_en_hi & m_wave_hi) ^ m_inv_hi);
      chk(cur_req, "pin_lo", 32'(pin_lo), 32'(epl));
      chk(cur_req, "pin_hi", 32'(pin_hi), 32'(eph));
      chk((cur_req == "R7") ? "R7" : "R5", "flag", 32'(cmp_flag_lo), 32'(m_flag));
      chk((cur_req == "R6") ? "R6" : "R5", "evt", 32'(cmp_evt_lo), 32'(m_evt));
      chk("R8", "irq", 32'(cmp_irq_lo), 32'(m_flag & m_ie));
      chk("R11", "unf", {30'd0, unf_hi, unf_lo}, {30'd0, m_unf_hi, m_unf_lo});
   endtask

   task automatic cycle();
      @(posedge clk);
      @(negedge clk);
      check_all();
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
      cycle();
      wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      for (int k = 0; k < n; k++) cycle();
   endtask

   logic [7:0] lf = 8'h5A;

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int highs;
      // R1: reset state
      run(2);
      chk("R1", "outputs in reset", {pin_lo, pin_hi, cmp_flag_lo, cmp_evt_lo, unf_lo, unf_hi}, '0);
      rst_n = 1'b1;
      cycle();
      chk("R1", "outputs after reset", {pin_lo, pin_hi, cmp_flag_lo, cmp_irq_lo, unf_lo, unf_hi}, '0);

      // R2: program the register map
      cur_req = "R2";
      wr(0, 5); wr(1, 3);
      wr(8, 0); wr(9, 2); wr(10, 5); wr(11, 7);
      wr(12, 1); wr(13, 3);
      wr(2, 'hF); wr(3, 'h3); wr(7, 'h5);
      dir_lo = '1; dir_hi = '1;
      cycle();

      // R4: free-running waveforms
      cur_req = "R4";
      tick = 1'b1;
      run(40);

      // R4: duty sweep on channel 0, period 5
      for (int c = 0; c < 8; c++) begin
         wr(8, c);
         run(8);
         highs = 0;
         for (int k = 0; k < 12; k++) begin
            cycle();
            highs += int'(pin_lo[0]);
         end
         chk("R4", $sformatf("duty cmp=%0d", c), 32'(highs),
             32'((c >= 1 && c <= 5) ? 2 * c : 0));
      end
      wr(8, 3);

      // R12: irregular timer-clock enable
      cur_req = "R12";
      for (int k = 0; k < 80; k++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         tick = lf[0];
         cycle();
      end
      tick = 1'b1;

      // R3: period changes below and above the running count
      cur_req = "R3";
      run(3);
      wr(0, 2);
      run(15);
      wr(0, 9);
      run(25);
      wr(1, 6);
      run(2);
      wr(1, 1);
      run(20);

      // R7 / R11: clears, including collisions with hardware sets
      cur_req = "R7";
      wr(6, 'hFF);
      for (int k = 0; k < 24; k++) wr(6, (k % 3 == 0) ? 'hFF : 'h45);
      run(12);

      // R9 / R10: direction, enable and invert combinations
      cur_req = "R9";
      for (int k = 0; k < 16; k++) begin
         dir_lo = NL'(k); dir_hi = NH'(k >> 2);
         wr(2, k ^ 'h6);
         run(3);
      end
      cur_req = "R10";
      dir_lo = '1; dir_hi = '1; wr(2, 'hF); wr(3, 'h3);
      for (int k = 0; k < 16; k++) begin
         wr(4, k);
         wr(5, k >> 1);
         run(5);
      end
      wr(4, 0); wr(5, 0);

      // R6: only the high lane matches
      cur_req = "R6";
      wr(8, 200); wr(9, 200); wr(10, 200); wr(11, 200);
      run(6);
      wr(6, 'h0F);
      for (int k = 0; k < 20; k++) begin
         cycle();
         chk("R6", "no low event", 32'(cmp_evt_lo), 32'd0);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule